// File: doc/BRIEF.md
# Programmable down-counter divider

This block is a presettable binary down counter built from identical 4-bit digits. It is meant to divide an incoming count clock by a programmed value N. Every digit is a small counter that loads asynchronously and is cleared asynchronously. The digits borrow from one another, so the whole chain counts as a single number. A zero-detect output marks the terminal state. That output is gated by a cascade-feedback control and by the preset-enable pin. When cascade feedback is high, a count event that finds the chain at zero reloads it on its own, and the zero output then pulses once every N count events.

The design runs on a single system clock, `clk`. The count clock and the inhibit pin are ordinary synchronous inputs. Both are sampled on `clk`, and an edge detector turns them into count events. A count event is either a rising edge of the count clock while inhibit is low, or a falling edge of inhibit while the count clock stays high. In the second case, inhibit acts as a second, negative-edge clock. Reset and preset enable act on the count register without waiting for a clock edge. No part of the block carries streamed data, so there is no valid/ready handshake and every pin is a plain level.

Top module: `dcnt_chain`

## Requirements
- R1: A count event decrements `count_o`, read as one binary number with bit 0 as the LSB, by one, wrapping from zero to all-ones. The new value appears after the `clk` rising edge that samples the event. A digit borrows from the next digit up only when every lower digit is zero.
- R2: While `inhibit_i` is high, a rising edge of `tick_clk_i` leaves `count_o` unchanged.
- R3: While `tick_clk_i` stays high, a falling edge of `inhibit_i` is a count event and decrements `count_o` by one.
- R4: `rst` high clears `count_o` to zero at once, without waiting for a clock edge. It wins over `preset_en_i`.
- R5: While `rst` is low, `preset_en_i` high loads `count_o` from `preset_i` at once (bit 0 is the LSB). The count keeps that value while preset enable stays high.
- R6: With `cascade_fb_i` high and `preset_en_i` low, `zero_o` is high exactly while `count_o` is all zeros. When the chain reloads, that state lasts one count period.
- R7: While `rst` is high, `zero_o` equals `cascade_fb_i`.
- R8: With `cascade_fb_i` low, `zero_o` equals `preset_en_i` and no reload takes place, so the count wraps from zero to all-ones.
- R9: With `cascade_fb_i` high, a count event at zero loads `preset_i` minus one, taken modulo 2^(digits×4). The zero pulse therefore repeats every N count events, and N = 0 gives a period of 16^digits.
- R10: With `cascade_fb_i` high, `zero_o` stays low while preset enable is high. After preset enable falls, it reflects the loaded value, so a preset of zero raises it at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the count clock and inhibit |
| rst | input | 1 | Asynchronous clear, active high |
| tick_clk_i | input | 1 | Count clock, rising edge counts |
| inhibit_i | input | 1 | Blocks counting; its falling edge counts while `tick_clk_i` is high |
| preset_en_i | input | 1 | Asynchronous load of `preset_i`, active high |
| cascade_fb_i | input | 1 | Enables terminal-count detection and auto-reload |
| preset_i | input | NUM_DIGITS*DIGIT_W | Divide value N |
| count_o | output | NUM_DIGITS*DIGIT_W | Current count |
| zero_o | output | 1 | Zero / terminal-count output |

## Verification
Two cases can fall in the same cycle. In the first, reset and preset enable are both high. The bench raises preset enable while reset is asserted and expects a cleared count and a `zero_o` equal to cascade feedback. It then releases reset with preset still high and expects the preset value on the next edge. In the second, a count event arrives while the chain sits at zero. That event must produce the reload value and not the all-ones wrap, and a scoreboard fed by a reference count compares both the count and the zero output after every event.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;

  // Source of a count event seen by the edge detector.
  typedef enum logic [1:0] {
    EV_NONE     = 2'd0,
    EV_CLK_RISE = 2'd1,
    EV_INH_FALL = 2'd2
  } dcnt_ev_e;

  function automatic logic ev_active(dcnt_ev_e e);
    return e != EV_NONE;
  endfunction

endpackage

// File: rtl/dcnt_tick_detect.sv
module dcnt_tick_detect
  import dcnt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_i,
  input  logic     tick_clk_i,
  input  logic     inhibit_i,
  output dcnt_ev_e src_o
);

  logic tc_q, inh_q;

  always_ff @(posedge clk or posedge rst_i) begin
    if (rst_i) begin
      tc_q  <= 1'b0;
      inh_q <= 1'b0;
    end else begin
      tc_q  <= tick_clk_i;
      inh_q <= inhibit_i;
    end
  end

  // A rising count clock counts only with inhibit low; with the count clock
  // parked high, a falling inhibit edge counts instead.
  always_comb begin
    src_o = EV_NONE;
    if (tick_clk_i && !tc_q && !inhibit_i)
      src_o = EV_CLK_RISE;
    else if (tick_clk_i && tc_q && inh_q && !inhibit_i)
      src_o = EV_INH_FALL;
  end

  a_r2_inhibit_blocks: assert property (@(posedge clk) disable iff (rst_i)
    inhibit_i |-> src_o == EV_NONE);

endmodule

// File: rtl/dcnt_digit.sv
module dcnt_digit #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_i,
  input  logic         pe_i,
  input  logic [W-1:0] data_i,
  input  logic         dec_i,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  output logic [W-1:0] q_o,
  output logic         zero_o
);

  // Clear has priority over the asynchronous load; the clocked branches
  // hold the loaded value while preset enable stays high.
  always_ff @(posedge clk or posedge rst_i or posedge pe_i) begin
    if (rst_i)       q_o <= '0;
    else if (pe_i)   q_o <= data_i;
    else if (load_i) q_o <= load_data_i;
    else if (dec_i)  q_o <= q_o - W'(1);
  end

  assign zero_o = (q_o == '0);

  a_r1_step: assert property (@(posedge clk) disable iff (rst_i || pe_i)
    (dec_i && !load_i) |=> q_o == W'($past(q_o) - W'(1)));

  a_r5_preset_tracks: assert property (@(posedge clk) disable iff (rst_i)
    pe_i |=> (!pe_i || q_o == $past(data_i)));

endmodule

// File: rtl/dcnt_chain.sv
module dcnt_chain
  import dcnt_pkg::*;
#(
  parameter int DIGIT_W    = 4,
  parameter int NUM_DIGITS = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          tick_clk_i,
  input  logic                          inhibit_i,
  input  logic                          preset_en_i,
  input  logic                          cascade_fb_i,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] preset_i,
  output logic [NUM_DIGITS*DIGIT_W-1:0] count_o,
  output logic                          zero_o
);

  localparam int CW = NUM_DIGITS * DIGIT_W;

  dcnt_ev_e              ev_src;
  logic                  tick_ev;
  logic [CW-1:0]         reload_val;
  logic [NUM_DIGITS-1:0] dz;
  logic [NUM_DIGITS-1:0] borrow;
  logic                  all_zero;
  logic                  reload;

  dcnt_tick_detect u_tick (
    .clk        (clk),
    .rst_i      (rst),
    .tick_clk_i (tick_clk_i),
    .inhibit_i  (inhibit_i),
    .src_o      (ev_src)
  );

  assign tick_ev    = ev_active(ev_src);
  assign reload_val = preset_i - CW'(1);
  assign all_zero   = &dz;
  assign reload     = tick_ev && cascade_fb_i && all_zero && !preset_en_i;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    if (g == 0) begin : g_lsd
      assign borrow[g] = 1'b1;
    end else begin : g_upper
      assign borrow[g] = borrow[g-1] & dz[g-1];
    end

    dcnt_digit #(.W(DIGIT_W)) u_digit (
      .clk         (clk),
      .rst_i       (rst),
      .pe_i        (preset_en_i),
      .data_i      (preset_i[g*DIGIT_W +: DIGIT_W]),
      .dec_i       (tick_ev && borrow[g]),
      .load_i      (reload),
      .load_data_i (reload_val[g*DIGIT_W +: DIGIT_W]),
      .q_o         (count_o[g*DIGIT_W +: DIGIT_W]),
      .zero_o      (dz[g])
    );
  end

  always_comb begin
    if (rst)               zero_o = cascade_fb_i;
    else if (cascade_fb_i) zero_o = !preset_en_i && all_zero;
    else                   zero_o = preset_en_i;
  end

  a_r6_zero_terminal: assert property (@(posedge clk) disable iff (rst || preset_en_i)
    (cascade_fb_i && zero_o) |-> count_o == '0);

  a_r9_reload: assert property (@(posedge clk) disable iff (rst || preset_en_i)
    (tick_ev && zero_o) |=> count_o == CW'($past(preset_i) - CW'(1)));

endmodule

// File: tb/test_dcnt_chain.sv
module test_dcnt_chain;
  localparam int DW = 4;
  localparam int ND = 2;
  localparam int CW = DW * ND;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1;
  logic          tick_clk = 1'b0;
  logic          inhibit = 1'b0;
  logic          pe = 1'b0;
  logic          cf = 1'b1;
  logic [CW-1:0] preset = '0;
  logic [CW-1:0] count;
  logic          zero;

  dcnt_chain #(.DIGIT_W(DW), .NUM_DIGITS(ND)) i_dcnt_chain (
    .clk(clk), .rst(rst), .tick_clk_i(tick_clk), .inhibit_i(inhibit),
    .preset_en_i(pe), .cascade_fb_i(cf), .preset_i(preset),
    .count_o(count), .zero_o(zero)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [CW:0]   exp_q[$];
  logic [CW-1:0] ref_cnt = '0;
  logic [CW-1:0] ref_n = '0;
  string         cur_req = "R1";
  bit            finished = 0;
  event          mon_ev;

  task automatic chk(string req, logic [CW-1:0] act, logic [CW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Reference: reload at zero when cascade feedback is high, else wrap.
  task automatic push_model();
    if (cf && ref_cnt == '0) ref_cnt = ref_n - CW'(1);
    else                     ref_cnt = ref_cnt - CW'(1);
    exp_q.push_back({cf && (ref_cnt == '0), ref_cnt});
  endtask

  task automatic tick();
    @(negedge clk) tick_clk = 1'b1;
    push_model();
    @(negedge clk) -> mon_ev;
    tick_clk = 1'b0;
  endtask

  task automatic set_preset(logic [CW-1:0] v);
    preset = v;
    @(negedge clk) pe = 1'b1;
    @(negedge clk) pe = 1'b0;
    ref_cnt = v;
    ref_n = v;
  endtask

  // Monitor: pops expected items and compares with the outputs.
  always begin
    logic [CW:0] item;
    @(mon_ev);
    if (exp_q.size() > 0) begin
      item = exp_q.pop_front();
      chk({cur_req, " count"}, count, item[CW-1:0]);
      chk({cur_req, " zero"}, CW'(zero), CW'(item[CW]));
    end
  end

  initial begin
    int pulses;
    repeat (3) @(negedge clk);
    chk("R4 reset count", count, '0);
    chk("R7 zero follows cf in reset", CW'(zero), CW'(1));
    cf = 1'b0; #1;
    chk("R7 zero follows cf low in reset", CW'(zero), CW'(0));
    cf = 1'b1;
    preset = 8'h5A;
    @(negedge clk) pe = 1'b1;
    @(negedge clk);
    chk("R4 reset beats preset", count, '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R5 preset loads after reset release", count, 8'h5A);
    chk("R10 zero low while preset high", CW'(zero), CW'(0));
    pe = 1'b0;
    @(negedge clk);
    chk("R5 value kept after preset falls", count, 8'h5A);

    // Divide by 5: reload and single-period zero pulses.
    set_preset(8'h05);
    cur_req = "R6/R9 divide-by-5";
    pulses = 0;
    for (int i = 0; i < 15; i++) begin
      tick();
      if (zero) pulses++;
    end
    chk("R9 pulses in 15 events for N=5", CW'(pulses), CW'(3));

    // Two-digit value with borrow between digits.
    set_preset(8'h23);
    cur_req = "R1/R9 divide-by-35";
    for (int i = 0; i < 40; i++) tick();

    // Inhibit blocks a rising count clock.
    cur_req = "R2";
    @(negedge clk) inhibit = 1'b1;
    @(negedge clk) tick_clk = 1'b1;
    @(negedge clk);
    chk("R2 rising clock ignored under inhibit", count, ref_cnt);
    // Inhibit falling with the count clock held high counts.
    cur_req = "R3 inhibit as clock";
    inhibit = 1'b0;
    push_model();
    @(negedge clk) -> mon_ev;
    tick_clk = 1'b0;
    @(negedge clk);
    cur_req = "R3 second inhibit edge";
    tick_clk = 1'b1; inhibit = 1'b1;
    @(negedge clk);
    @(negedge clk) inhibit = 1'b0;
    push_model();
    @(negedge clk) -> mon_ev;
    tick_clk = 1'b0;
    @(negedge clk);

    // Cascade feedback low: zero follows preset enable, count wraps.
    cf = 1'b0;
    preset = 8'h01;
    @(negedge clk) pe = 1'b1;
    #1 chk("R8 zero follows preset enable high", CW'(zero), CW'(1));
    @(negedge clk) pe = 1'b0;
    #1 chk("R8 zero follows preset enable low", CW'(zero), CW'(0));
    ref_cnt = 8'h01; ref_n = 8'h01;
    cur_req = "R8 wrap";
    tick();
    tick();
    chk("R8 wrap to all-ones", count, 8'hFF);

    // Preset of zero with cascade feedback high.
    cf = 1'b1;
    preset = 8'h00;
    @(negedge clk) pe = 1'b1;
    @(negedge clk);
    chk("R10 zero held low during preset", CW'(zero), CW'(0));
    pe = 1'b0; #1;
    chk("R10 zero valid after preset falls", CW'(zero), CW'(1));
    ref_cnt = '0; ref_n = '0;
    cur_req = "R9 N=0 reload";
    tick();
    tick();

    // Divide by 1 keeps zero high.
    set_preset(8'h01);
    cur_req = "R9 divide-by-1";
    for (int i = 0; i < 4; i++) tick();

    // Asynchronous reset in the middle of a count.
    set_preset(8'h37);
    cur_req = "R1 before reset";
    tick();
    @(negedge clk);
    #1 rst = 1'b1;
    #0.5;
    chk("R4 asynchronous clear", count, '0);
    chk("R7 zero equals cf during reset", CW'(zero), CW'(1));
    @(negedge clk) rst = 1'b0;
    @(negedge clk);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule